// File: doc/BRIEF.md
# AND-Rotate Unit with Decimal Nybble Correction

This block executes one arithmetic step of an 8-bit processor core. It masks the accumulator with an immediate operand, then rotates the masked value one place to the right with the incoming carry shifted into the top bit. In binary mode the rotated byte becomes the new accumulator. The carry and overflow flags follow an adder-style rule rather than the usual shift rule.

When the decimal flag is set, each nybble of the rotated byte can receive a +6 correction. Whether it does depends on the matching nybble of the masked value. Several flags are also taken from different points in the computation. The core's sequencer asserts a one-cycle start strobe with the operands and the current status byte. One clock later the unit returns the new accumulator and status byte, together with a done pulse. The outputs then hold until the next start.

Top module: `arr_unit`

## Requirements
- R1: With the decimal flag clear, the accumulator result equals {carry_in, m[7:1]}, where m = accIn & immIn.
- R2: The status byte uses bit 7 = N, bit 6 = V, bit 3 = D, bit 1 = Z and bit 0 = C. With D clear, N is bit 7 of the result and Z is set exactly when the result is zero.
- R3: With D clear, C takes bit 6 of the result, and V takes bit 6 XOR bit 5 of the result.
- R4: With D set, N takes the incoming carry. Z is set exactly when the rotated value is zero, and this test is made before any correction.
- R5: With D set, V is bit 6 of (m XOR rotated value).
- R6: With D set, let mL be the low nybble of m. If mL + mL[0] exceeds 5, the low nybble of the result is the low nybble of the rotated value plus 6, wrapping within four bits. Otherwise that nybble is unchanged.
- R7: With D set, let mH be the high nybble of m. If mH + mH[0] exceeds 5, 0x60 is added to the result modulo 256 and C is set. Otherwise the high nybble is unchanged and C is cleared.
- R8: Status bits 5 to 2 of statusOut equal those of statusIn captured at start.
- R9: done is high in exactly the cycle after a start. accOut and statusOut change only in that cycle and otherwise hold their values.
- R10: While reset is asserted, accOut, statusOut and done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to execute |
| accIn | input | 8 | Accumulator operand |
| immIn | input | 8 | Immediate operand |
| statusIn | input | 8 | Status byte before the operation |
| accOut | output | 8 | New accumulator |
| statusOut | output | 8 | Status byte after the operation |
| done | output | 1 | Result valid pulse, one cycle after start |

## Verification
The bench targets the threshold cases of the correction rule. A nybble value of 4 must receive no correction, while 5 and 6 must. A unit that tests the raw nybble instead of nybble plus its low bit would leave 5 uncorrected. The masked value 0x55 with carry in gives a corrected result of zero while Z stays clear. A design that computes Z after the correction would set Z here, and one that lets the low correction carry upward would not reach zero. Binary cases with bit 5 and bit 6 set apart expose a V or C taken from the wrong bit.

// File: rtl/arr_pkg.sv
package arr_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int NIB_CNT = DATA_W / NIB_W;

  localparam int FLAG_N = 7;
  localparam int FLAG_V = 6;
  localparam int FLAG_D = 3;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  localparam logic [NIB_W-1:0] NIB_ADJ   = 4'd6;
  localparam logic [NIB_W:0]   NIB_LIMIT = 5'd5;

  typedef struct packed {
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/arr_nib_fix.sv
module arr_nib_fix
  import arr_pkg::*;
(
  input  logic [NIB_W-1:0] maskNib,
  input  logic [NIB_W-1:0] rotNib,
  output logic [NIB_W-1:0] fixedNib,
  output logic             applied
);
  logic [NIB_W:0] weighted;

  always_comb begin
    weighted = {1'b0, maskNib} + {{NIB_W{1'b0}}, maskNib[0]};
    applied  = weighted > NIB_LIMIT;
    fixedNib = applied ? rotNib + NIB_ADJ : rotNib;
  end
endmodule

// File: rtl/arr_ctrl.sv
module arr_ctrl
  import arr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         done
);
  always_comb strobes.load = start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end
endmodule

// File: rtl/arr_datapath.sv
module arr_datapath
  import arr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] immIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] statusOut
);
  logic [DATA_W-1:0]  masked;
  logic [DATA_W-1:0]  rotated;
  logic [DATA_W-1:0]  corrected;
  logic [NIB_CNT-1:0] nibApplied;
  logic               carryIn;
  logic               decMode;
  logic [DATA_W-1:0]  accNext;
  logic [DATA_W-1:0]  statusNext;

  always_comb begin
    carryIn = statusIn[FLAG_C];
    decMode = statusIn[FLAG_D];
    masked  = accIn & immIn;
    rotated = {carryIn, masked[DATA_W-1:1]};
  end

  for (genvar g = 0; g < NIB_CNT; g++) begin : g_nib
    arr_nib_fix u_fix (
      .maskNib  (masked[g*NIB_W +: NIB_W]),
      .rotNib   (rotated[g*NIB_W +: NIB_W]),
      .fixedNib (corrected[g*NIB_W +: NIB_W]),
      .applied  (nibApplied[g])
    );
  end

  always_comb begin
    statusNext = statusIn;
    statusNext[FLAG_Z] = (rotated == '0);
    if (decMode) begin
      accNext = corrected;
      statusNext[FLAG_N] = carryIn;
      statusNext[FLAG_V] = masked[6] ^ rotated[6];
      statusNext[FLAG_C] = nibApplied[NIB_CNT-1];
    end else begin
      accNext = rotated;
      statusNext[FLAG_N] = rotated[DATA_W-1];
      statusNext[FLAG_V] = rotated[6] ^ rotated[5];
      statusNext[FLAG_C] = rotated[6];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut    <= '0;
      statusOut <= '0;
    end else if (strobes.load) begin
      accOut    <= accNext;
      statusOut <= statusNext;
    end
  end
endmodule

// File: rtl/arr_unit.sv
module arr_unit
  import arr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] immIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] statusOut,
  output logic              done
);
  ctrlStrobes_t strobes;

  arr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  arr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accIn     (accIn),
    .immIn     (immIn),
    .statusIn  (statusIn),
    .accOut    (accOut),
    .statusOut (statusOut)
  );
endmodule

// File: rtl/arr_unit_chk.sv
module arr_unit_chk
  import arr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] statusIn,
  input logic [DATA_W-1:0] accOut,
  input logic [DATA_W-1:0] statusOut,
  input logic              done
);
  p_done_after_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(accOut) && $stable(statusOut)));

  p_pass_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (statusOut[5:2] == $past(statusIn[5:2])));

  p_dec_neg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (start && statusIn[FLAG_D]) |=> (statusOut[FLAG_N] == $past(statusIn[FLAG_C])));

  p_bin_nz_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !statusIn[FLAG_D]) |=>
      (statusOut[FLAG_N] == accOut[7] && statusOut[FLAG_Z] == (accOut == '0)));

  p_bin_cv_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !statusIn[FLAG_D]) |=>
      (statusOut[FLAG_C] == accOut[6] && statusOut[FLAG_V] == (accOut[6] ^ accOut[5])));

  p_bin_top_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !statusIn[FLAG_D]) |=> (accOut[7] == $past(statusIn[FLAG_C])));
endmodule

bind arr_unit arr_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .statusIn  (statusIn),
  .accOut    (accOut),
  .statusOut (statusOut),
  .done      (done)
);

// File: tb/arr_unit_bench.sv
module arr_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] immIn = '0;
  logic [7:0] statusIn = '0;
  logic [7:0] accOut;
  logic [7:0] statusOut;
  logic       done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  arr_unit u_arr_unit (
    .clk(clk), .rstN(rstN), .start(start), .accIn(accIn), .immIn(immIn),
    .statusIn(statusIn), .accOut(accOut), .statusOut(statusOut), .done(done)
  );

  // {acc, imm, statusIn, expected acc, expected status}
  localparam logic [39:0] VEC [13] = '{
    {8'hFF, 8'hFF, 8'h00, 8'h7F, 8'h01},  // R1 R3 binary, C from bit 6
    {8'hFF, 8'hFF, 8'h01, 8'hFF, 8'h81},  // R1 R2 carry into top
    {8'h01, 8'h01, 8'h34, 8'h00, 8'h36},  // R2 R8 zero result
    {8'h40, 8'hFF, 8'h00, 8'h20, 8'h40},  // R3 V from bit6^bit5
    {8'hF0, 8'h3C, 8'h00, 8'h18, 8'h00},  // R1 masking
    {8'hFF, 8'hFF, 8'h08, 8'hD5, 8'h09},  // R6 R7 both corrections
    {8'h00, 8'h00, 8'h09, 8'h80, 8'h88},  // R4 N from carry in
    {8'h00, 8'h00, 8'h08, 8'h00, 8'h0A},  // R4 zero
    {8'h05, 8'hFF, 8'h08, 8'h08, 8'h08},  // R6 low nybble 5 corrected
    {8'h04, 8'hFF, 8'h08, 8'h02, 8'h08},  // R6 low nybble 4 not corrected
    {8'h50, 8'hFF, 8'h08, 8'h88, 8'h49},  // R7 R5 high nybble 5
    {8'h40, 8'hFF, 8'h08, 8'h20, 8'h48},  // R7 R5 high nybble 4
    {8'h55, 8'hFF, 8'h09, 8'h00, 8'hC9}   // R4 Z before correction
  };

  function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] m,
                                        input logic [7:0] st);
    logic [7:0] t, r, res, so;
    int lo, hi;
    t = a & m;
    r = {st[0], t[7:1]};
    so = st;
    so[1] = (r == 8'h00);
    if (st[3]) begin
      res = r;
      lo = int'(t[3:0]) + int'(t[0]);
      hi = int'(t[7:4]) + int'(t[4]);
      if (lo > 5) res[3:0] = res[3:0] + 4'd6;
      if (hi > 5) res = res + 8'h60;
      so[7] = st[0];
      so[6] = t[6] ^ r[6];
      so[0] = (hi > 5);
    end else begin
      res = r;
      so[7] = r[7];
      so[6] = r[6] ^ r[5];
      so[0] = r[6];
    end
    return {res, so};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [7:0] a, input logic [7:0] m, input logic [7:0] st);
    @(negedge clk);
    accIn = a; immIn = m; statusIn = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    logic [7:0] holdA, holdS;
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    check("R10 reset acc", {24'h0, accOut}, 32'h0);
    check("R10 reset status", {24'h0, statusOut}, 32'h0);
    check("R10 reset done", {31'h0, done}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < 13; i++) begin
      runOp(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
      check("R9 done", {31'h0, done}, 32'h1);
      check("R1-vector acc", {24'h0, accOut}, {24'h0, VEC[i][15:8]});
      check("R2 vector status", {24'h0, statusOut}, {24'h0, VEC[i][7:0]});
    end

    // R9: outputs hold, done drops, while inputs change without start
    holdA = accOut; holdS = statusOut;
    @(negedge clk);
    accIn = 8'hAA; immIn = 8'hFF; statusIn = 8'hFF;
    @(negedge clk);
    check("R9 done single", {31'h0, done}, 32'h0);
    check("R9 acc held", {24'h0, accOut}, {24'h0, holdA});
    check("R9 status held", {24'h0, statusOut}, {24'h0, holdS});

    // R8 pass-through with all other bits set
    runOp(8'h12, 8'hFF, 8'hFC);
    exp = model(8'h12, 8'hFF, 8'hFC);
    check("R8 pass bits", {28'h0, statusOut[5:2]}, {28'h0, exp[5:2]});

    // R5 R6 R7 pseudo-random sweep against the requirement model
    seed = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      runOp(seed[31:24], seed[23:16], seed[15:8]);
      exp = model(seed[31:24], seed[23:16], seed[15:8]);
      check("R6 R7 sweep acc", {24'h0, accOut}, {24'h0, exp[15:8]});
      check("R5 R4 sweep status", {24'h0, statusOut}, {24'h0, exp[7:0]});
    end

    // R10 reset mid-operation clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R10 reset again", {16'h0, accOut, statusOut}, 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule